// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the two serial clocks of a stereo audio link in master mode: a bit clock and a left/right word clock. Both come from one counter that runs on the fast master clock, so they are frequency-locked and phase-aligned to it. No derived clock is used as a clock inside the block. Every output is a register bit in the master-clock domain.

Two static configuration inputs choose the operating point. `ratio_sel` sets how many master-clock cycles make one sample frame (64, 128, 256 or 512). `long_frame` sets the number of bit-clock periods per frame (32 or 64). The integer divide from master clock to bit clock is the ratio divided by the frame length. It is always at least two, so the bit clock is a registered signal in every mode. Two one-cycle strobes mark bit and frame boundaries, so that downstream shifters can run on the master clock with clock enables.

A change on either configuration input restarts the shared counter at the start of a left-channel frame. From there the new pattern runs with full-width periods only.

Top module: `aud_sclk_gen`

## Requirements
- R1: While `rst_n` is low, all four outputs are low.
- R2: One frame (one word-clock period) lasts 64, 128, 256 or 512 master-clock cycles for `ratio_sel` values 0, 1, 2 and 3.
- R3: The word clock is low for the first half of each frame (left channel) and high for the second half (right channel), which gives exactly 50% duty.
- R4: With `long_frame` low a frame holds 32 bit-clock periods, and with `long_frame` high it holds 64. When `ratio_sel` is 0, `long_frame` is ignored and the frame holds 32 periods.
- R5: A bit period lasts (frame cycles / bit periods per frame) master-clock cycles. The bit clock is low in its first half and high in its second half.
- R6: The word clock changes only in a cycle in which the bit clock falls, except on a configuration restart.
- R7: `bit_stb_o` is high for exactly the one master-clock cycle before each bit-clock falling edge.
- R8: `frame_stb_o` is high for exactly the one cycle before each word-clock transition, and it is never high without `bit_stb_o`.
- R9: In the cycle after either configuration input changes, all outputs are low and the counter is at the start of a left-channel frame. The new pattern follows from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Frame length select in master-clock cycles: 0=64, 1=128, 2=256, 3=512 |
| long_frame | input | 1 | 0: 32 bit periods per frame; 1: 64 (ignored when ratio_sel is 0) |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock, low = left, high = right |
| bit_stb_o | output | 1 | One-cycle strobe before each bit-clock falling edge |
| frame_stb_o | output | 1 | One-cycle strobe before each word-clock transition |

## Verification
The assertions on edge alignment and strobes assume that the configuration inputs change only as single-cycle steps that the block sees as a restart. They exclude the cycle right after a restart, where the word clock may drop without a bit-clock fall. The bench changes the configuration inputs only on falling master-clock edges. It holds each setting for at least one full frame, except for one deliberate mid-frame change that exercises the restart. Reset is released on a falling edge, so that the first counted cycle is well defined.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  function automatic logic [31:0] lowmask(input int n);
    if (n <= 0) return 32'd0;
    return 32'hFFFF_FFFF >> (32 - n);
  endfunction
endpackage

// File: rtl/aclk_cfg.sv
module aclk_cfg #(
  parameter int SEL_W          = 2,
  parameter int MIN_RATIO_LOG2 = 6,
  parameter int MIN_BPF_LOG2   = 5,
  parameter int LOG_W          = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             long_frame,
  output logic             restart,
  output logic [LOG_W-1:0] frm_log2,
  output logic [LOG_W-1:0] bit_log2
);
  localparam int CFG_W = SEL_W + 1;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [LOG_W-1:0] bpf_log2;

  always_comb begin
    cfg_d   = {ratio_sel, long_frame};
    restart = (cfg_d != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (restart) cfg_q <= cfg_d;
  end

  always_comb begin
    frm_log2 = LOG_W'(MIN_RATIO_LOG2) + LOG_W'(cfg_q[CFG_W-1:1]);
    if (cfg_q[0] && (cfg_q[CFG_W-1:1] != '0)) bpf_log2 = LOG_W'(MIN_BPF_LOG2 + 1);
    else                                      bpf_log2 = LOG_W'(MIN_BPF_LOG2);
    bit_log2 = frm_log2 - bpf_log2;
  end

  AST_CFG_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart || !$stable({ratio_sel, long_frame})); // R9
endmodule

// File: rtl/aclk_div.sv
module aclk_div #(
  parameter int CNT_W = 9,
  parameter int LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [LOG_W-1:0] frm_log2,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q
);
  import aclk_pkg::*;

  logic [CNT_W-1:0] wrap_mask;

  always_comb begin
    wrap_mask = CNT_W'(lowmask(int'(frm_log2)));
    if (restart) cnt_d = '0;
    else         cnt_d = (cnt_q + CNT_W'(1)) & wrap_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R9

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt_q == wrap_mask) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/aclk_out.sv
module aclk_out #(
  parameter int CNT_W = 9,
  parameter int LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [LOG_W-1:0] frm_log2,
  input  logic [LOG_W-1:0] bit_log2,
  output logic             bclk_q,
  output logic             wclk_q,
  output logic             bit_stb_q,
  output logic             frame_stb_q
);
  import aclk_pkg::*;

  logic [CNT_W-1:0] bit_mask, half_mask;
  logic [LOG_W-1:0] bit_sel, frm_sel;
  logic             bclk_d, wclk_d, bit_stb_d, frame_stb_d;

  always_comb begin
    bit_sel     = bit_log2 - LOG_W'(1);
    frm_sel     = frm_log2 - LOG_W'(1);
    bit_mask    = CNT_W'(lowmask(int'(bit_log2)));
    half_mask   = CNT_W'(lowmask(int'(frm_sel)));
    bclk_d      = cnt_d[bit_sel];
    wclk_d      = cnt_d[frm_sel];
    bit_stb_d   = ((cnt_d & bit_mask) == bit_mask);
    frame_stb_d = ((cnt_d & half_mask) == half_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q      <= 1'b0;
      wclk_q      <= 1'b0;
      bit_stb_q   <= 1'b0;
      frame_stb_q <= 1'b0;
    end else begin
      bclk_q      <= bclk_d;
      wclk_q      <= wclk_d;
      bit_stb_q   <= bit_stb_d;
      frame_stb_q <= frame_stb_d;
    end
  end

  AST_WCLK_ON_BFALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(restart) && !$stable(wclk_q)) |-> $fell(bclk_q)); // R6

  AST_BSTB_LEADS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb_q && !restart) |=> $fell(bclk_q)); // R7

  AST_FSTB_WITH_BSTB: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_q |-> bit_stb_q); // R8
endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen #(
  parameter int SEL_W          = 2,
  parameter int MIN_RATIO_LOG2 = 6,
  parameter int MIN_BPF_LOG2   = 5
) (
  input  logic             clk_m,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             long_frame,
  output logic             bclk_o,
  output logic             wclk_o,
  output logic             bit_stb_o,
  output logic             frame_stb_o
);
  localparam int MAX_RATIO_LOG2 = MIN_RATIO_LOG2 + (1 << SEL_W) - 1;
  localparam int CNT_W          = MAX_RATIO_LOG2;
  localparam int LOG_W          = $clog2(MAX_RATIO_LOG2 + 1);

  logic             restart;
  logic [LOG_W-1:0] frm_log2, bit_log2;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  aclk_cfg #(.SEL_W(SEL_W), .MIN_RATIO_LOG2(MIN_RATIO_LOG2),
             .MIN_BPF_LOG2(MIN_BPF_LOG2), .LOG_W(LOG_W)) u_cfg (
    .clk(clk_m), .rst_n(rst_n), .ratio_sel(ratio_sel), .long_frame(long_frame),
    .restart(restart), .frm_log2(frm_log2), .bit_log2(bit_log2));

  aclk_div #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_div (
    .clk(clk_m), .rst_n(rst_n), .restart(restart), .frm_log2(frm_log2),
    .cnt_d(cnt_d), .cnt_q(cnt_q));

  aclk_out #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_out (
    .clk(clk_m), .rst_n(rst_n), .restart(restart), .cnt_d(cnt_d),
    .frm_log2(frm_log2), .bit_log2(bit_log2),
    .bclk_q(bclk_o), .wclk_q(wclk_o), .bit_stb_q(bit_stb_o),
    .frame_stb_q(frame_stb_o));

  AST_RESET_QUIET: assert property (@(posedge clk_m) disable iff (!rst_n)
    $rose(rst_n) |-> !bclk_o && !wclk_o); // R1
endmodule

// File: tb/sim_aud_sclk_gen.sv
module sim_aud_sclk_gen;
  logic       clk_m = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic       long_frame = 1'b0;
  logic       bclk_o, wclk_o, bit_stb_o, frame_stb_o;

  int total = 0;
  int bad   = 0;
  int m_cnt = 0;
  int m_sel = 0;
  int m_lf  = 0;
  int fall_seen = 0;

  always #4 clk_m = ~clk_m;

  aud_sclk_gen u0 (.clk_m(clk_m), .rst_n(rst_n), .ratio_sel(ratio_sel),
                   .long_frame(long_frame), .bclk_o(bclk_o), .wclk_o(wclk_o),
                   .bit_stb_o(bit_stb_o), .frame_stb_o(frame_stb_o));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%0b exp=%0b (sel=%0d lf=%0d cnt=%0d)",
               req, $time, act, exp, m_sel, m_lf, m_cnt);
    end
  endtask

  task automatic compare();
    int ratio, bpf, dv;
    ratio = 64 << m_sel;
    bpf   = (m_sel != 0 && m_lf != 0) ? 64 : 32;
    dv    = ratio / bpf;
    if (!rst_n) begin
      chk("R1 bclk", bclk_o, 1'b0);
      chk("R1 wclk", wclk_o, 1'b0);
      chk("R1 bstb", bit_stb_o, 1'b0);
      chk("R1 fstb", frame_stb_o, 1'b0);
    end else begin
      chk("R5/R4 bclk", bclk_o, (m_cnt % dv) >= dv / 2);
      chk("R3/R2 wclk", wclk_o, m_cnt >= ratio / 2);
      chk("R7 bstb", bit_stb_o, (m_cnt % dv) == dv - 1);
      chk("R8 fstb", frame_stb_o, (m_cnt % (ratio / 2)) == ratio / 2 - 1);
    end
  endtask

  task automatic advance();
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_lf = 0;
    end else if (int'(ratio_sel) != m_sel || int'(long_frame) != m_lf) begin
      m_cnt = 0; m_sel = int'(ratio_sel); m_lf = int'(long_frame);
    end else begin
      m_cnt = (m_cnt + 1) % (64 << m_sel);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_m);
      compare();
      advance();
    end
  endtask

  task automatic setcfg(input int s, input int lf);
    @(negedge clk_m);
    compare();
    ratio_sel  = 2'(s);
    long_frame = lf[0];
    advance();
  endtask

  // R6: count word-clock steps that line up with a bit-clock fall
  logic prev_b = 1'b0, prev_w = 1'b0;
  always @(negedge clk_m) begin
    if (rst_n && prev_b && !bclk_o && (prev_w != wclk_o)) fall_seen++;
    prev_b <= bclk_o;
    prev_w <= wclk_o;
  end

  initial begin
    fork
      begin
        run(5);
        @(negedge clk_m); compare(); rst_n = 1'b1; advance();
        for (int s = 0; s < 4; s++) begin
          for (int lf = 0; lf < 2; lf++) begin
            setcfg(s, lf);
            run((64 << s) * 2 + 7);
          end
        end
        setcfg(1, 0);
        run(150);
        setcfg(3, 1);                // R9: change in mid-frame
        run(40);
        setcfg(2, 0);                // R9
        run(600);
        setcfg(0, 1);                // R4: long_frame ignored at the smallest ratio
        run(200);
        @(negedge clk_m); compare(); rst_n = 1'b0; advance();
        run(4);
        @(negedge clk_m); compare(); rst_n = 1'b1; advance();
        run(300);
        total++;
        if (fall_seen == 0) begin
          bad++;
          $display("FAIL R6 act=%0d exp>0 word-clock steps on bit-clock falls", fall_seen);
        end
      end
      begin
        repeat (100000) @(posedge clk_m);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule